// File: doc/BRIEF.md
# Receive Slot Buffer with Completion Commands

This block takes received Ethernet frames one word per beat and keeps only what a downstream packet processor needs. It drops the two MAC addresses and stores the EtherType with the IP packet that follows it in a dual-port RAM. The RAM is split into a whole number of equal slots. Each frame takes one slot, whatever its length. The slots are used in circular order, so the buffer wraps exactly at a slot boundary.

When the last word of a frame has been written, the block queues a 32-bit completion command that holds the slot's start address and the number of stored bytes. The consumer pops the command from a valid/ready stream and reads the packet through a plain read port. It then pulses an acknowledge, which releases the oldest occupied slot.

The block discards a frame and raises a one-cycle flag in three cases: it starts while every slot is taken, it ends inside the MAC header, or it does not fit in one slot. A discarded frame never produces a command and never takes a slot.

Back-pressure rules: the input side never stalls. `in_ready` is high whenever reset is released, and every beat with `in_valid` high is taken. On the command side, a command stays in the queue and `cmd_data` holds steady until a cycle with both `cmd_valid` and `cmd_ready` high. The command queue has one entry per slot. The consumer must pop a command before it acknowledges that command's slot.

Top module: `rxslot_cmdgen`

## Requirements
- R1: Beats are 32-bit words with byte 0 in bits [31:24]. The first 3 beats of a frame (the 12 MAC address bytes) are not stored. The 4th beat, which carries the EtherType in its upper 16 bits, is written to the first word of the slot, and each following beat goes to the next word.
- R2: Slot k starts at word address k*400, with 4 slots by default. Slots are handed out in order 0,1,2,3 and then back to 0.
- R3: A command holds the slot start address in bits [15:0] and the stored byte count in bits [29:16]. Bits [31:30] are zero. The byte count is 4*(stored words-1) plus `in_tail` of the last beat, where a tail of 0 means 4 bytes.
- R4: `cmd_valid` rises in the cycle after the last beat is accepted, and not earlier.
- R5: A frame that stores more than 400 words is rejected: `pkt_reject` pulses for one cycle after its last beat, no command is produced, and the next frame gets the same slot. A frame of exactly 400 stored words is accepted.
- R6: A frame whose last beat falls within the first 3 beats is rejected in the same way as in R5, with no command.
- R7: A frame that starts while all slots are occupied is dropped whole. `ovf_drop` pulses in the cycle after its first beat, nothing is written to the RAM, and no command is produced.
- R8: Each `cmd_ack` pulse releases the oldest occupied slot. An acknowledge while no slot is occupied is ignored.
- R9: `buf_empty` is high when no slot is occupied and `buf_full` is high when all are occupied. After reset the buffer is empty and `cmd_valid` is low.
- R10: Commands leave in the order the frames completed. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds steady. `in_ready` is high whenever reset is released.
- R11: The read port returns the word at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted (high out of reset) |
| in_first | input | 1 | Beat is the first of a frame |
| in_last | input | 1 | Beat is the last of a frame |
| in_tail | input | 2 | Valid bytes in the last beat, 0 meaning 4 |
| in_data | input | 32 | Frame data, byte 0 in [31:24] |
| cmd_valid | output | 1 | Completion command available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 32 | {2'b0, size[13:0], pointer[15:0]} |
| cmd_ack | input | 1 | Pulse: oldest slot has been read out |
| rd_addr | input | 11 | Consumer read word address |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |
| ovf_drop | output | 1 | Pulse: frame dropped because no slot was free |
| pkt_reject | output | 1 | Pulse: frame rejected as too long or too short |

## Verification
The bench fills every slot and then sends one more frame. A design that checks free space at the wrong point, or that writes the dropped frame anyway, overwrites a stored packet or queues a stray command. It sends frames of exactly 400 and 401 stored words, plus frames that end inside the header. A design off by one at the slot edge either loses a legal frame or spills into the next slot, and a design that consumes a slot on rejection shifts every later pointer. It also sends a spurious acknowledge on an empty buffer and checks the wrap from the last slot back to slot 0. A design whose counter underflows, or whose pointer does not wrap, never reports full again or hands out an address outside the RAM.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;
  localparam int PTR_W     = 16;
  localparam int SIZE_W    = 14;
  localparam int MAC_BYTES = 12;

  typedef struct packed {
    logic [1:0]        pad;
    logic [SIZE_W-1:0] size;
    logic [PTR_W-1:0]  ptr;
  } rx_cmd_t;
endpackage

// File: rtl/rxslot_ram.sv
module rxslot_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1600,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxslot_cmdfifo.sv
module rxslot_cmdfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign do_push   = push && (cnt_q != CW'(DEPTH));
  assign do_pop    = pop_ready && (cnt_q != '0);
  assign pop_valid = (cnt_q != '0);
  assign pop_data  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rxslot_writer.sv
module rxslot_writer #(
  parameter int DATA_W     = 32,
  parameter int SLOT_WORDS = 400,
  parameter int NUM_SLOTS  = 4,
  parameter int AW         = 11,
  parameter int TAIL_W     = 2,
  parameter int HDR_WORDS  = 3,
  parameter int PTR_W      = 16,
  parameter int SIZE_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [TAIL_W-1:0] in_tail,
  input  logic              slot_free,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic              commit,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic [SIZE_W-1:0] cmd_size,
  output logic              ovf_pulse,
  output logic              rej_pulse
);
  localparam int BPW       = DATA_W / 8;
  localparam int POS_W     = $clog2(SLOT_WORDS + HDR_WORDS + 2);
  localparam int LAST_BASE = (NUM_SLOTS - 1) * SLOT_WORDS;

  logic [POS_W-1:0] pos_q, pos_now, body_idx;
  logic             keep_q, keep_now, long_q, long_now;
  logic             in_hdr, over;
  logic [AW-1:0]    head_q;
  logic [TAIL_W:0]  tail_bytes;

  always_comb begin
    pos_now    = in_first ? '0 : pos_q;
    keep_now   = in_first ? slot_free : keep_q;
    in_hdr     = pos_now < POS_W'(HDR_WORDS);
    body_idx   = pos_now - POS_W'(HDR_WORDS);
    over       = !in_hdr && (body_idx >= POS_W'(SLOT_WORDS));
    long_now   = (in_first ? 1'b0 : long_q) | over;
    tail_bytes = (in_tail == '0) ? (TAIL_W+1)'(BPW) : {1'b0, in_tail};
    ram_we     = in_valid && keep_now && !in_hdr && !over;
    ram_addr   = head_q + AW'(body_idx);
    commit     = in_valid && in_last && keep_now && !in_hdr && !long_now;
    cmd_ptr    = PTR_W'(head_q);
    cmd_size   = SIZE_W'(body_idx) * SIZE_W'(BPW) + SIZE_W'(tail_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      keep_q    <= 1'b0;
      long_q    <= 1'b0;
      head_q    <= '0;
      ovf_pulse <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      ovf_pulse <= in_valid && in_first && !slot_free;
      rej_pulse <= in_valid && in_last && keep_now && (in_hdr || long_now);
      if (in_valid) begin
        if (pos_now != '1) pos_q <= pos_now + 1'b1;
        else               pos_q <= pos_now;
        keep_q <= keep_now && !in_last;
        long_q <= long_now;
      end
      if (commit)
        head_q <= (head_q == AW'(LAST_BASE)) ? '0 : head_q + AW'(SLOT_WORDS);
    end
  end
endmodule

// File: rtl/rxslot_cmdgen.sv
module rxslot_cmdgen
  import rxslot_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SLOT_WORDS = 400,
  parameter int NUM_SLOTS  = 4,
  parameter int ADDR_W     = $clog2(NUM_SLOTS * SLOT_WORDS),
  parameter int TAIL_W     = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [TAIL_W-1:0] in_tail,
  input  logic [DATA_W-1:0] in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_data,
  input  logic              cmd_ack,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              buf_empty,
  output logic              ovf_drop,
  output logic              pkt_reject
);
  localparam int DEPTH     = NUM_SLOTS * SLOT_WORDS;
  localparam int HDR_WORDS = MAC_BYTES / (DATA_W / 8);
  localparam int OCC_W     = $clog2(NUM_SLOTS + 1);

  logic              ram_we, commit, slot_free, release_slot;
  logic [ADDR_W-1:0] ram_addr;
  logic [PTR_W-1:0]  cmd_ptr;
  logic [SIZE_W-1:0] cmd_size;
  logic [OCC_W-1:0]  occ_q;
  logic              rdy_q;
  rx_cmd_t           push_cmd;

  assign slot_free    = (occ_q != OCC_W'(NUM_SLOTS));
  assign release_slot = cmd_ack && (occ_q != '0);
  assign buf_full     = !slot_free;
  assign buf_empty    = (occ_q == '0);
  assign in_ready     = rdy_q;

  always_comb begin
    push_cmd.pad  = 2'b00;
    push_cmd.size = cmd_size;
    push_cmd.ptr  = cmd_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      occ_q <= occ_q + OCC_W'(commit) - OCC_W'(release_slot);
    end
  end

  rxslot_writer #(
    .DATA_W(DATA_W), .SLOT_WORDS(SLOT_WORDS), .NUM_SLOTS(NUM_SLOTS),
    .AW(ADDR_W), .TAIL_W(TAIL_W), .HDR_WORDS(HDR_WORDS),
    .PTR_W(PTR_W), .SIZE_W(SIZE_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid && rdy_q), .in_first(in_first), .in_last(in_last),
    .in_tail(in_tail), .slot_free(slot_free),
    .ram_we(ram_we), .ram_addr(ram_addr), .commit(commit),
    .cmd_ptr(cmd_ptr), .cmd_size(cmd_size),
    .ovf_pulse(ovf_drop), .rej_pulse(pkt_reject)
  );

  rxslot_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  rxslot_cmdfifo #(.W($bits(rx_cmd_t)), .DEPTH(NUM_SLOTS)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .push(commit), .push_data(push_cmd),
    .pop_valid(cmd_valid), .pop_ready(cmd_ready), .pop_data(cmd_data)
  );
endmodule

// File: rtl/rxslot_chk.sv
module rxslot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_first,
  input logic        in_last,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_data,
  input logic        cmd_ack,
  input logic        buf_full,
  input logic        buf_empty,
  input logic        ovf_drop,
  input logic        pkt_reject
);
  // R9
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R3
  cmd_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_data[31:30] == 2'b00 && cmd_data[29:16] != 14'd0));

  // R7
  ovf_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |-> $past(in_valid && in_first));

  // R5
  reject_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_reject |-> $past(in_valid && in_last));

  // R8
  full_clears_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(buf_full) && !buf_full) |-> $past(cmd_ack));

  // R6
  drop_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_drop && pkt_reject));
endmodule

bind rxslot_cmdgen rxslot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_last(in_last), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .cmd_ack(cmd_ack), .buf_full(buf_full),
  .buf_empty(buf_empty), .ovf_drop(ovf_drop), .pkt_reject(pkt_reject)
);

// File: tb/rxslot_cmdgen_tb.sv
module rxslot_cmdgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int SW  = 400;
  localparam int HW  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [1:0]  in_tail = 2'd0;
  logic [31:0] in_data = '0;
  logic        in_ready, cmd_valid, buf_full, buf_empty, ovf_drop, pkt_reject;
  logic        cmd_ready = 1'b0, cmd_ack = 1'b0;
  logic [31:0] cmd_data, rd_data;
  logic [10:0] rd_addr = '0;

  int total = 0, bad = 0;
  int ovf_seen = 0, rej_seen = 0;
  int exp_head = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxslot_cmdgen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_tail(in_tail), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_ack(cmd_ack), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_full(buf_full), .buf_empty(buf_empty),
    .ovf_drop(ovf_drop), .pkt_reject(pkt_reject)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && ovf_drop)   ovf_seen++;
    if (rst_n && pkt_reject) rej_seen++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] mkcmd(input int ptr, input int size);
    return {2'b00, 14'(size), 16'(ptr)};
  endfunction

  // nbeats counts header beats too; body word i = {tagv, i}
  task automatic send(input int nbeats, input int tail, input logic [15:0] tagv);
    for (int b = 0; b < nbeats; b++) begin
      in_valid = 1'b1;
      in_first = (b == 0);
      in_last  = (b == nbeats - 1);
      in_tail  = (b == nbeats - 1) ? 2'(tail) : 2'd0;
      in_data  = (b < HW) ? (32'hEEEE_0000 + 32'(b)) : {tagv, 16'(b - HW)};
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_tail = 2'd0;
  endtask

  task automatic pop(input string req, input int ptr, input int size);
    chk({req, " cmd_valid"}, 32'(cmd_valid), 32'd1);
    chk({req, " cmd_data"}, cmd_data, mkcmd(ptr, size));
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic ack1();
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 11'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    chk("R9 empty after reset", 32'(buf_empty), 32'd1);
    chk("R9 full after reset", 32'(buf_full), 32'd0);
    chk("R9 cmd_valid after reset", 32'(cmd_valid), 32'd0);
    chk("R10 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_single();
    logic [31:0] d, held;
    for (int b = 0; b < HW + 10; b++) begin
      in_valid = 1'b1;
      in_first = (b == 0);
      in_last  = (b == HW + 9);
      in_tail  = (b == HW + 9) ? 2'd2 : 2'd0;
      in_data  = (b < HW) ? (32'hEEEE_0000 + 32'(b)) : {16'h0011, 16'(b - HW)};
      @(negedge clk);
      if (b == HW + 8) chk("R4 no cmd before last", 32'(cmd_valid), 32'd0);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    chk("R4 cmd after last", 32'(cmd_valid), 32'd1);
    held = cmd_data;
    cycles(3);
    chk("R10 cmd_data held", cmd_data, held);
    chk("R9 not empty", 32'(buf_empty), 32'd0);
    rd(0, d);  chk("R1 first stored word", d, {16'h0011, 16'd0});
    rd(9, d);  chk("R11 last stored word", d, {16'h0011, 16'd9});
    pop("R3 single", 0, 9*4 + 2);
    ack1();
    chk("R8 empty after ack", 32'(buf_empty), 32'd1);
    exp_head = SW;
  endtask

  task automatic t_fill();
    logic [31:0] d;
    int o0;
    for (int k = 0; k < NS; k++) send(HW + 5, 0, 16'h0A00 + 16'(k));
    chk("R9 full", 32'(buf_full), 32'd1);
    o0 = ovf_seen;
    send(HW + 5, 0, 16'hBAD0);
    cycles(2);
    chk("R7 overflow flagged", 32'(ovf_seen - o0), 32'd1);
    for (int k = 0; k < NS; k++) pop("R2 fill order", (SW * (k + 1)) % (SW * NS), 20);
    chk("R7 no cmd for dropped", 32'(cmd_valid), 32'd0);
    rd(SW, d); chk("R7 no write for dropped", d, {16'h0A00, 16'd0});
    ack1();
    chk("R8 not full after ack", 32'(buf_full), 32'd0);
    for (int k = 0; k < NS - 1; k++) ack1();
    chk("R8 empty", 32'(buf_empty), 32'd1);
    ack1();
    chk("R8 spurious ack empty", 32'(buf_empty), 32'd1);
    for (int k = 0; k < NS; k++) send(HW + 2, 3, 16'h0B00 + 16'(k));
    chk("R8 full after spurious ack", 32'(buf_full), 32'd1);
    for (int k = 0; k < NS; k++) pop("R2 wrap", (SW * (k + 1)) % (SW * NS), 7);
    for (int k = 0; k < NS; k++) ack1();
    chk("R9 empty again", 32'(buf_empty), 32'd1);
  endtask

  task automatic t_long();
    logic [31:0] d;
    int r0 = rej_seen;
    send(HW + SW + 1, 0, 16'h0C01);
    cycles(2);
    chk("R5 too long rejected", 32'(rej_seen - r0), 32'd1);
    chk("R5 no cmd", 32'(cmd_valid), 32'd0);
    chk("R5 slot kept free", 32'(buf_empty), 32'd1);
    send(HW + SW, 0, 16'h0C02);
    pop("R5 exact fit", exp_head, SW * 4);
    rd(exp_head + SW - 1, d); chk("R5 last word", d, {16'h0C02, 16'(SW - 1)});
    ack1();
    exp_head = (exp_head + SW) % (SW * NS);
  endtask

  task automatic t_runt();
    int r0 = rej_seen;
    send(2, 0, 16'h0D00);
    send(HW, 0, 16'h0D01);
    cycles(2);
    chk("R6 runts rejected", 32'(rej_seen - r0), 32'd2);
    chk("R6 no cmd", 32'(cmd_valid), 32'd0);
    send(HW + 1, 1, 16'h0D02);
    pop("R6 next gets slot", exp_head, 1);
    ack1();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_single();
    t_fill();
    t_long();
    t_runt();
    cycles(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule